// File: doc/BRIEF.md
# Host Bus Interface Decoder

This block is the host-facing front end of a peripheral that occupies sixteen I/O locations. It matches the upper address bits, qualified by an active-low address-enable, against a configurable base. It turns each accepted host access into one single-cycle read or write pulse toward an internal register file. The pulse carries a 4-bit register index and four byte-lane enables, so byte, 16-bit and 32-bit accesses are all supported. A separate active-low data-select input bypasses the decoder and always targets the data register with all four lanes enabled.

Two host protocols share the decoder. The strobe protocol uses separate active-low read and write strobes and pulls its ready output low as soon as a matching strobe appears, holding it low through a programmable wait. The clocked protocol starts a cycle on address strobe plus cycle enable, inserts the same wait, then drives an active-low ready output. On a clocked read, the data stays held until the host returns its own active-low ready. An optional address latch follows the address bus while the address strobe is low and keeps the last captured value once the strobe goes high. All inputs are sampled on one clock, and the two protocols may alternate but never overlap.

Top module: `hbi_decoder`

## Requirements
- R1: Without data-select, an access is accepted only when `aen` is 0 and `haddr[15:4]` equals `BASE_TAG` (default 12'h030); any other address produces no pulse and leaves both ready outputs idle.
- R2: While `dsel_n` is 0, the decoder is bypassed: the access is accepted whatever `haddr`, `aen` and `be_n` hold, `reg_idx` equals `DATA_IDX` (default 4'h8) and `reg_lane` is 4'b1111.
- R3: For a decoded access, `reg_idx` equals address bits [3:0] and `reg_lane[i]` equals the inverse of `be_n[i]`, so byte (one lane), word (two lanes) and double-word (four lanes) accesses are all carried.
- R4: With `LATCH_EN`=1, the effective address equals `haddr` on any clock where `ads_n` is 0; while `ads_n` is 1 it equals the `haddr` value sampled at the last clock edge where `ads_n` was 0.
- R5: On the strobe protocol, `ardy` goes to 0 in the same cycle a matching `rd_n` or `wr_n` low is seen in idle. It stays 0 until `WAIT_CYC`+2 clock edges after the first edge that sampled the strobe, then returns to 1.
- R6: Each accepted access gives exactly one `reg_rd` or `reg_wr` pulse, one cycle wide, WAIT_CYC+1 edges after the starting edge. `reg_wr` is chosen for `wr_n` low or `swr`=1. No second pulse follows until the strobe is released or the clocked cycle ends.
- R7: On the clocked protocol, a cycle starts on an edge where `ads_n` and `cyc_n` are both 0 and the address matches. `srdy_n` is 0 from WAIT_CYC+2 edges after the start; for a write it stays 0 for exactly one cycle.
- R8: After a read pulse, `host_rdata` holds the `reg_rdata` value present during the pulse. On a clocked read, `srdy_n` and `host_rdata` stay unchanged until an edge samples `rdyrtn_n` at 0, and `srdy_n` returns to 1 after that edge.
- R9: Strobe-protocol and clocked-protocol accesses can follow one another back to back, each completing with its own index and lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| haddr | input | 16 | Host address bus |
| aen | input | 1 | Address-enable qualifier, 0 = valid I/O address |
| be_n | input | 4 | Active-low byte enables |
| dsel_n | input | 1 | Active-low data-register select, bypasses decoding |
| ads_n | input | 1 | Active-low address strobe; also starts clocked cycles |
| rd_n | input | 1 | Active-low read strobe (strobe protocol) |
| wr_n | input | 1 | Active-low write strobe (strobe protocol) |
| ardy | output | 1 | Strobe-protocol ready, 0 = wait |
| cyc_n | input | 1 | Active-low cycle enable (clocked protocol) |
| swr | input | 1 | Clocked-protocol direction, 1 = write |
| srdy_n | output | 1 | Clocked-protocol ready, 0 = ready |
| rdyrtn_n | input | 1 | Active-low host ready-return ending a clocked read |
| reg_rd | output | 1 | Single-cycle register read pulse |
| reg_wr | output | 1 | Single-cycle register write pulse |
| reg_idx | output | 4 | Register index carried with the pulse |
| reg_lane | output | 4 | Byte-lane enables carried with the pulse |
| reg_rdata | input | 32 | Register file read data, valid during `reg_rd` |
| host_rdata | output | 32 | Held read data returned to the host |

## Verification
The assertions take for granted that the host never runs a strobe access and a clocked access at the same time. They also assume the strobes and cycle controls are synchronous to `clk`, and that `reg_rdata` is valid in the cycle of `reg_rd`. The stimulus issues every access through tasks that complete one transaction, including the strobe release or ready-return, before the next begins. Inputs change only a short time after each rising edge. Miss, data-select, latched-address and transparent-address accesses are spread over both protocols so that each of these input conditions is reached.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WAIT  = 2'd1,
        PH_PULSE = 2'd2,
        PH_END   = 2'd3
    } phase_e;

    localparam int IDX_W  = 4;
    localparam int LANE_W = 4;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [LANE_W-1:0] lane;
        logic              wr;
    } req_t;

endpackage

// File: rtl/hbi_addr_stage.sv
module hbi_addr_stage #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 4,
    parameter int LANES  = 4,
    parameter logic [ADDR_W-IDX_W-1:0] BASE_TAG = '0,
    parameter bit LATCH_EN = 1'b1,
    parameter logic [IDX_W-1:0] DATA_IDX = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ads_n,
    input  logic              aen,
    input  logic              dsel_n,
    input  logic [LANES-1:0]  be_n,
    output logic              hit,
    output logic [IDX_W-1:0]  idx,
    output logic [LANES-1:0]  lane
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [ADDR_W-1:0] eff_addr;
    logic [TAG_W-1:0]  tag;

    generate
        if (LATCH_EN) begin : g_latch
            logic [ADDR_W-1:0] lat_d, lat_q;

            always_comb begin
                lat_d = ads_n ? lat_q : addr;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) lat_q <= '0;
                else        lat_q <= lat_d;
            end

            assign eff_addr = lat_d;

            // R4: with the strobe high over two edges the latched address does not move
            a_r4_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
                (ads_n && $past(ads_n)) |-> $stable(eff_addr));
        end else begin : g_direct
            assign eff_addr = addr;
        end
    endgenerate

    assign tag = eff_addr[ADDR_W-1:IDX_W];

    always_comb begin
        if (!dsel_n) begin
            hit  = 1'b1;
            idx  = DATA_IDX;
            lane = '1;
        end else begin
            hit  = !aen && (tag == BASE_TAG);
            idx  = eff_addr[IDX_W-1:0];
            lane = ~be_n;
        end
    end

endmodule

// File: rtl/hbi_strobe_port.sv
module hbi_strobe_port
    import hbi_pkg::*;
#(
    parameter int WAIT_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              hit,
    input  logic [IDX_W-1:0]  idx_in,
    input  logic [LANE_W-1:0] lane_in,
    output logic              ardy,
    output logic              pulse_rd,
    output logic              pulse_wr,
    output logic [IDX_W-1:0]  idx_out,
    output logic [LANE_W-1:0] lane_out,
    output logic              busy
);
    localparam int CNT_W = (WAIT_CYC < 1) ? 1 : $clog2(WAIT_CYC + 1);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        req_t             req;
    } st_t;

    st_t  st_d, st_q;
    logic strobe;

    assign strobe = !rd_n || !wr_n;

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (strobe && hit) begin
                    st_d.ph       = PH_WAIT;
                    st_d.cnt      = CNT_W'(WAIT_CYC);
                    st_d.req.idx  = idx_in;
                    st_d.req.lane = lane_in;
                    st_d.req.wr   = !wr_n;
                end
            end
            PH_WAIT: begin
                if (st_q.cnt == '0) st_d.ph  = PH_PULSE;
                else                st_d.cnt = st_q.cnt - 1'b1;
            end
            PH_PULSE: st_d.ph = PH_END;
            PH_END: begin
                if (!strobe) st_d.ph = PH_IDLE;
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ph: PH_IDLE, cnt: '0, req: '0};
        else        st_q <= st_d;
    end

    assign ardy     = !((st_q.ph == PH_IDLE && strobe && hit) ||
                        st_q.ph == PH_WAIT || st_q.ph == PH_PULSE);
    assign pulse_rd = (st_q.ph == PH_PULSE) && !st_q.req.wr;
    assign pulse_wr = (st_q.ph == PH_PULSE) &&  st_q.req.wr;
    assign idx_out  = st_q.req.idx;
    assign lane_out = st_q.req.lane;
    assign busy     = (st_q.ph != PH_IDLE);

    // R5: ready comes back on the edge right after the register pulse
    a_r5_ready_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_rd || pulse_wr) |=> ardy);

    // R6: a pulse never lasts two cycles on this port
    a_r6_strobe_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_rd || pulse_wr) |=> !(pulse_rd || pulse_wr));

endmodule

// File: rtl/hbi_clocked_port.sv
module hbi_clocked_port
    import hbi_pkg::*;
#(
    parameter int WAIT_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ads_n,
    input  logic              cyc_n,
    input  logic              swr,
    input  logic              rdyrtn_n,
    input  logic              hit,
    input  logic [IDX_W-1:0]  idx_in,
    input  logic [LANE_W-1:0] lane_in,
    output logic              srdy_n,
    output logic              pulse_rd,
    output logic              pulse_wr,
    output logic [IDX_W-1:0]  idx_out,
    output logic [LANE_W-1:0] lane_out,
    output logic              busy,
    output logic              rd_hold
);
    localparam int CNT_W = (WAIT_CYC < 1) ? 1 : $clog2(WAIT_CYC + 1);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        req_t             req;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (!ads_n && !cyc_n && hit) begin
                    st_d.ph       = PH_WAIT;
                    st_d.cnt      = CNT_W'(WAIT_CYC);
                    st_d.req.idx  = idx_in;
                    st_d.req.lane = lane_in;
                    st_d.req.wr   = swr;
                end
            end
            PH_WAIT: begin
                if (st_q.cnt == '0) st_d.ph  = PH_PULSE;
                else                st_d.cnt = st_q.cnt - 1'b1;
            end
            PH_PULSE: st_d.ph = PH_END;
            PH_END: begin
                if (st_q.req.wr || !rdyrtn_n) st_d.ph = PH_IDLE;
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ph: PH_IDLE, cnt: '0, req: '0};
        else        st_q <= st_d;
    end

    assign srdy_n   = (st_q.ph != PH_END);
    assign pulse_rd = (st_q.ph == PH_PULSE) && !st_q.req.wr;
    assign pulse_wr = (st_q.ph == PH_PULSE) &&  st_q.req.wr;
    assign idx_out  = st_q.req.idx;
    assign lane_out = st_q.req.lane;
    assign busy     = (st_q.ph != PH_IDLE);
    assign rd_hold  = (st_q.ph == PH_END) && !st_q.req.wr;

    // R7: the register pulse is followed by ready on the next cycle
    a_r7_ready_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_rd || pulse_wr) |=> !srdy_n);

    // R7: a write acknowledge lasts one cycle only
    a_r7_write_ack_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (!srdy_n && !rd_hold) |=> srdy_n);

    // R8: a held read keeps ready low until the host returns ready
    a_r8_wait_for_return: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hold && rdyrtn_n) |=> !srdy_n);

endmodule

// File: rtl/hbi_decoder.sv
module hbi_decoder
    import hbi_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32,
    parameter int WAIT_CYC = 3,
    parameter logic [ADDR_W-IDX_W-1:0] BASE_TAG = 12'h030,
    parameter bit LATCH_EN = 1'b1,
    parameter logic [IDX_W-1:0] DATA_IDX = 4'h8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] haddr,
    input  logic              aen,
    input  logic [LANE_W-1:0] be_n,
    input  logic              dsel_n,
    input  logic              ads_n,
    input  logic              rd_n,
    input  logic              wr_n,
    output logic              ardy,
    input  logic              cyc_n,
    input  logic              swr,
    output logic              srdy_n,
    input  logic              rdyrtn_n,
    output logic              reg_rd,
    output logic              reg_wr,
    output logic [IDX_W-1:0]  reg_idx,
    output logic [LANE_W-1:0] reg_lane,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic [DATA_W-1:0] host_rdata
);
    logic              dec_hit;
    logic [IDX_W-1:0]  dec_idx;
    logic [LANE_W-1:0] dec_lane;

    logic              a_rd, a_wr, a_busy;
    logic [IDX_W-1:0]  a_idx;
    logic [LANE_W-1:0] a_lane;
    logic              s_rd, s_wr, s_busy, s_hold;
    logic [IDX_W-1:0]  s_idx;
    logic [LANE_W-1:0] s_lane;

    logic [DATA_W-1:0] rdata_d, rdata_q;

    hbi_addr_stage #(
        .ADDR_W  (ADDR_W),
        .IDX_W   (IDX_W),
        .LANES   (LANE_W),
        .BASE_TAG(BASE_TAG),
        .LATCH_EN(LATCH_EN),
        .DATA_IDX(DATA_IDX)
    ) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (haddr),
        .ads_n (ads_n),
        .aen   (aen),
        .dsel_n(dsel_n),
        .be_n  (be_n),
        .hit   (dec_hit),
        .idx   (dec_idx),
        .lane  (dec_lane)
    );

    hbi_strobe_port #(.WAIT_CYC(WAIT_CYC)) u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .hit     (dec_hit),
        .idx_in  (dec_idx),
        .lane_in (dec_lane),
        .ardy    (ardy),
        .pulse_rd(a_rd),
        .pulse_wr(a_wr),
        .idx_out (a_idx),
        .lane_out(a_lane),
        .busy    (a_busy)
    );

    hbi_clocked_port #(.WAIT_CYC(WAIT_CYC)) u_clocked (
        .clk     (clk),
        .rst_n   (rst_n),
        .ads_n   (ads_n),
        .cyc_n   (cyc_n),
        .swr     (swr),
        .rdyrtn_n(rdyrtn_n),
        .hit     (dec_hit),
        .idx_in  (dec_idx),
        .lane_in (dec_lane),
        .srdy_n  (srdy_n),
        .pulse_rd(s_rd),
        .pulse_wr(s_wr),
        .idx_out (s_idx),
        .lane_out(s_lane),
        .busy    (s_busy),
        .rd_hold (s_hold)
    );

    assign reg_rd   = a_rd || s_rd;
    assign reg_wr   = a_wr || s_wr;
    assign reg_idx  = (a_rd || a_wr) ? a_idx  : s_idx;
    assign reg_lane = (a_rd || a_wr) ? a_lane : s_lane;

    always_comb begin
        rdata_d = reg_rd ? reg_rdata : rdata_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign host_rdata = rdata_q;

    // R9: the host keeps the two protocols apart in time
    a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_busy && s_busy));

    // R6: read and write pulses never coincide
    a_r6_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_wr));

    // R8: held clocked read data stays put until the host returns ready
    a_r8_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        (s_hold && rdyrtn_n) |=> $stable(host_rdata));

endmodule

// File: tb/hbi_decoder_tb.sv
module hbi_decoder_tb;
    localparam int W = 3;
    localparam logic [11:0] BASE = 12'h030;
    localparam logic [3:0]  DIDX = 4'h8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] haddr = '0;
    logic        aen = 1'b0;
    logic [3:0]  be_n = 4'hF;
    logic        dsel_n = 1'b1, ads_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic        cyc_n = 1'b1, swr = 1'b0, rdyrtn_n = 1'b1;
    logic        ardy, srdy_n, reg_rd, reg_wr;
    logic [3:0]  reg_idx, reg_lane;
    logic [31:0] reg_rdata, host_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign reg_rdata = {16'hBEEF, 12'h000, reg_idx};

    hbi_decoder #(.WAIT_CYC(W), .BASE_TAG(BASE), .DATA_IDX(DIDX)) u_dut (
        .clk(clk), .rst_n(rst_n), .haddr(haddr), .aen(aen), .be_n(be_n),
        .dsel_n(dsel_n), .ads_n(ads_n), .rd_n(rd_n), .wr_n(wr_n), .ardy(ardy),
        .cyc_n(cyc_n), .swr(swr), .srdy_n(srdy_n), .rdyrtn_n(rdyrtn_n),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_lane(reg_lane),
        .reg_rdata(reg_rdata), .host_rdata(host_rdata)
    );

    // behavioural reference: age of each protocol's access in edges, -1 = none
    int          a_age = -1, s_age = -1;
    logic [3:0]  a_idx, a_lane, s_idx, s_lane;
    bit          a_wr, s_wr;
    logic [15:0] m_lat = '0;
    logic [31:0] m_rdata = '0;
    int          pulses = 0;
    logic [3:0]  last_idx, last_lane;
    bit          last_wr;

    function automatic logic [31:0] data_of(logic [3:0] i);
        return {16'hBEEF, 12'h000, i};
    endfunction

    function automatic bit hit_of(logic [15:0] lat);
        logic [15:0] e;
        e = ads_n ? lat : haddr;
        return !dsel_n || (!aen && e[15:4] == BASE);
    endfunction

    function automatic logic [3:0] idx_of(logic [15:0] lat);
        logic [15:0] e;
        e = ads_n ? lat : haddr;
        return !dsel_n ? DIDX : e[3:0];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            a_age = -1; s_age = -1; m_lat = '0; m_rdata = '0;
        end else begin
            bit h; bit strb;
            logic [3:0] ix, ln;
            h    = hit_of(m_lat);
            ix   = idx_of(m_lat);
            ln   = !dsel_n ? 4'hF : ~be_n;
            strb = !rd_n || !wr_n;
            if (a_age < 0) begin
                if (strb && h) begin a_age = 0; a_idx = ix; a_lane = ln; a_wr = !wr_n; end
            end else if (a_age <= W) a_age++;
            else if (a_age == W + 1) begin
                a_age++;
                if (!a_wr) m_rdata = data_of(a_idx);
            end else if (!strb) a_age = -1;
            if (s_age < 0) begin
                if (!ads_n && !cyc_n && h) begin s_age = 0; s_idx = ix; s_lane = ln; s_wr = swr; end
            end else if (s_age <= W) s_age++;
            else if (s_age == W + 1) begin
                s_age++;
                if (!s_wr) m_rdata = data_of(s_idx);
            end else if (s_wr || !rdyrtn_n) s_age = -1;
            if (!ads_n) m_lat = haddr;
        end
    end

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit e_rd, e_wr, e_ardy, strb;
            strb = !rd_n || !wr_n;
            e_rd = (a_age == W + 1 && !a_wr) || (s_age == W + 1 && !s_wr);
            e_wr = (a_age == W + 1 &&  a_wr) || (s_age == W + 1 &&  s_wr);
            chk(reg_rd == e_rd, "R6 reg_rd", reg_rd, e_rd);
            chk(reg_wr == e_wr, "R6 reg_wr", reg_wr, e_wr);
            if (a_age == W + 1) begin
                chk(reg_idx == a_idx,  "R3 idx strobe",  reg_idx,  a_idx);
                chk(reg_lane == a_lane, "R3 lane strobe", reg_lane, a_lane);
            end
            if (s_age == W + 1) begin
                chk(reg_idx == s_idx,  "R3 idx clocked",  reg_idx,  s_idx);
                chk(reg_lane == s_lane, "R3 lane clocked", reg_lane, s_lane);
            end
            e_ardy = !((a_age < 0 && strb && hit_of(m_lat)) || (a_age >= 0 && a_age <= W + 1));
            chk(ardy == e_ardy, "R5 ardy", ardy, e_ardy);
            chk(srdy_n == !(s_age == W + 2), "R7 srdy_n", srdy_n, !(s_age == W + 2));
            if ((a_age == W + 2 && !a_wr) || (s_age == W + 2 && !s_wr))
                chk(host_rdata == m_rdata, "R8 host_rdata", host_rdata, m_rdata);
            if (reg_rd || reg_wr) begin
                pulses++; last_idx = reg_idx; last_lane = reg_lane; last_wr = reg_wr;
            end
        end
    end

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic strobe_acc(logic [15:0] a, logic [3:0] be, bit wr, bit ds, bit ae, bit latch);
        dsel_n = !ds; aen = ae; be_n = be; haddr = a;
        if (latch) begin
            ads_n = 1'b0; tick(); ads_n = 1'b1; haddr = 16'hFFFF;
        end else ads_n = 1'b0;
        if (wr) wr_n = 1'b0; else rd_n = 1'b0;
        repeat (W + 4) tick();
        rd_n = 1'b1; wr_n = 1'b1; ads_n = 1'b1; dsel_n = 1'b1; be_n = 4'hF; aen = 1'b0;
        repeat (2) tick();
    endtask

    task automatic clocked_acc(logic [15:0] a, logic [3:0] be, bit wr, bit ds, bit ae, int rtn_delay);
        dsel_n = !ds; aen = ae; be_n = be; haddr = a; swr = wr;
        ads_n = 1'b0; cyc_n = 1'b0;
        tick();
        ads_n = 1'b1; cyc_n = 1'b1; haddr = 16'hFFFF;
        repeat (W + 2) tick();
        if (!wr) begin
            repeat (rtn_delay) tick();
            rdyrtn_n = 1'b0; tick(); rdyrtn_n = 1'b1;
        end
        dsel_n = 1'b1; be_n = 4'hF; aen = 1'b0; swr = 1'b0;
        repeat (2) tick();
    endtask

    initial begin
        int p0;
        repeat (3) tick();
        chk(ardy == 1'b1 && srdy_n == 1'b1, "R5 R7 reset ready", {ardy, srdy_n}, 2'b11);
        chk(!reg_rd && !reg_wr, "R6 reset pulses", {reg_rd, reg_wr}, 2'b00);
        rst_n = 1'b1;
        tick();

        // R3: byte, word and double-word strobe writes and reads, latched address (R4)
        p0 = pulses;
        strobe_acc(16'h0305, 4'b1110, 1'b1, 1'b0, 1'b0, 1'b1);
        chk(pulses == p0 + 1 && last_wr, "R6 one write pulse", pulses - p0, 1);
        chk(last_idx == 4'h5 && last_lane == 4'b0001, "R3 R4 byte lane latched", {last_idx, last_lane}, 8'h51);
        strobe_acc(16'h030A, 4'b1100, 1'b0, 1'b0, 1'b0, 1'b1);
        chk(last_idx == 4'hA && last_lane == 4'b0011, "R3 word lanes", {last_idx, last_lane}, 8'hA3);
        chk(host_rdata == 32'hBEEF000A, "R8 strobe read data", host_rdata, 32'hBEEF000A);
        strobe_acc(16'h030F, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0);
        chk(last_idx == 4'hF && last_lane == 4'hF, "R3 R4 dword transparent", {last_idx, last_lane}, 8'hFF);

        // R1: wrong base tag and raised aen are both ignored
        p0 = pulses;
        strobe_acc(16'h0405, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b1);
        clocked_acc(16'h0302, 4'b0000, 1'b1, 1'b0, 1'b1, 0);
        chk(pulses == p0, "R1 misses ignored", pulses - p0, 0);

        // R2: data-select overrides address, aen and byte enables
        strobe_acc(16'h1234, 4'b1111, 1'b1, 1'b1, 1'b1, 1'b0);
        chk(pulses == p0 + 1 && last_idx == DIDX && last_lane == 4'hF, "R2 data select strobe",
            {last_idx, last_lane}, {DIDX, 4'hF});
        clocked_acc(16'hFFF0, 4'b0101, 1'b0, 1'b1, 1'b0, 2);
        chk(last_idx == DIDX && last_lane == 4'hF && !last_wr, "R2 data select clocked",
            {last_idx, last_lane}, {DIDX, 4'hF});

        // R7 R8: clocked writes and reads with varied ready-return delay
        clocked_acc(16'h0303, 4'b0011, 1'b1, 1'b0, 1'b0, 0);
        chk(last_wr && last_idx == 4'h3 && last_lane == 4'b1100, "R7 clocked write",
            {last_idx, last_lane}, 8'h3C);
        clocked_acc(16'h0307, 4'b1101, 1'b0, 1'b0, 1'b0, 5);
        chk(host_rdata == 32'hBEEF0007, "R8 clocked read held", host_rdata, 32'hBEEF0007);
        chk(srdy_n == 1'b1, "R8 srdy released", srdy_n, 1'b1);

        // R9: alternating protocols back to back
        p0 = pulses;
        for (int k = 0; k < 6; k++) begin
            if (k % 2 == 0) strobe_acc(16'h0300 + 16'(k), 4'b1110, k[1], 1'b0, 1'b0, 1'b1);
            else            clocked_acc(16'h0300 + 16'(k), 4'b0000, k[1], 1'b0, 1'b0, k);
        end
        chk(pulses == p0 + 6, "R9 interleaved accesses", pulses - p0, 6);

        repeat (4) tick();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule